// File: doc/BRIEF.md
# SDRAM Periodic Auto-Refresh Engine

This block keeps an SDRAM device's cells alive once power-up initialization has finished. An interval timer starts running when the init-complete input is first seen high. When the interval runs out, the block raises a refresh request toward the memory controller's arbiter. The request stays up until the arbiter grants it.

On a grant, the engine takes over the SDRAM command pins. It closes every bank with a precharge that has A10 high. It waits the row-precharge time, then issues a fixed number of auto-refresh commands (two by default), each followed by the refresh-recovery wait. At the end it pulses a completion flag for one clock. Between commands it drives NOP.

The refresh interval and both waits are cycle-count parameters derived from the clock rate. Each refresh command restores only one row, and the device needs 4096 of them every 64 ms, which is one every 15.625 us. At 100 MHz the default interval is therefore 1500 cycles, a little under the 1562-cycle limit, so that arbitration delay still fits.

Top module: `sdram_refresh_engine`

## Requirements
- R1: While reset is held low, the outputs are in their idle state: request low, done low, the command pins at NOP ({cs_n,ras_n,cas_n,we_n} = 0111) and A10 low.
- R2: No request is raised before init_done has been sampled high. The first request rises REFI_CYCLES clock edges after the edge that first samples init_done high.
- R3: Once raised, the request stays high until it is sampled together with a grant.
- R4: A grant sampled with the request high puts PRECHARGE (0010) with A10 high on the command pins in the following cycle.
- R5: The first AUTO REFRESH (0001) comes exactly T_RP cycles after the PRECHARGE, with NOP and A10 low in the cycles between.
- R6: Exactly NUM_REFRESH AUTO REFRESH commands are issued per sequence, spaced T_RFC cycles apart, with NOP and A10 low in between.
- R7: done is high for exactly one cycle, T_RFC cycles after the final AUTO REFRESH, with NOP on the pins; otherwise it is low.
- R8: After a grant is accepted, the next request rises exactly REFI_CYCLES clock edges after the grant edge; the timer reloads at the start of each sequence.
- R9: A grant sampled while the request is low has no effect: no command other than NOP appears and the request stays low.
- R10: A10 is high only in the cycle carrying PRECHARGE; only NOP, PRECHARGE and AUTO REFRESH are ever driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, rising-edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| init_done | input | 1 | High once device initialization has finished |
| ref_grant | input | 1 | Arbiter grant for the pending refresh |
| ref_req | output | 1 | Refresh request toward the arbiter |
| ref_done | output | 1 | One-cycle pulse at the end of the refresh sequence |
| sdram_cs_n | output | 1 | Chip select, active low |
| sdram_ras_n | output | 1 | Row strobe, active low |
| sdram_cas_n | output | 1 | Column strobe, active low |
| sdram_we_n | output | 1 | Write enable, active low |
| sdram_a10 | output | 1 | Address bit 10; high selects all banks for precharge |

## Verification
The bench builds the engine with REFI_CYCLES = 40, T_RP = 3, T_RFC = 5 and NUM_REFRESH = 2. With these values two complete request, grant and sequence rounds fit in a few hundred cycles. The precharge wait and the recovery wait differ in length, so a swapped or off-by-one wait shows up in the cycle-exact command trace. The short interval also lets the bench measure the request spacing from both the init edge and the grant edge, hold a pending request unserved for several cycles, and apply stray grants before init and in the middle of a sequence.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP       = 4'b0111,
    CMD_PRECHARGE = 4'b0010,
    CMD_REFRESH   = 4'b0001
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PRE,
    SQ_WAIT_RP,
    SQ_REF,
    SQ_WAIT_RFC,
    SQ_DONE
  } seq_state_e;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int INTERVAL = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_done,
  input  logic start,
  output logic req
);
  localparam int CW = $clog2(INTERVAL);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic          armed;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
      req   <= 1'b0;
    end else begin
      armed <= armed | init_done;
      if (start) begin
        // sequence begins: reload the interval, retire the request
        cnt <= '0;
        req <= 1'b0;
      end else if (armed) begin
        if (cnt != LAST) cnt <= cnt + 1'b1;
        else             req <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ref_cmd_sequencer.sv
module ref_cmd_sequencer
  import sdram_ref_pkg::*;
#(
  parameter int T_RP        = 2,
  parameter int T_RFC       = 7,
  parameter int NUM_REFRESH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       idle,
  output sdram_cmd_e cmd,
  output logic       a10,
  output logic       done
);
  localparam int TMAX = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int WW   = $clog2(TMAX);
  localparam int RW   = $clog2(NUM_REFRESH + 1);
  localparam logic [WW-1:0] RP_LOAD  = WW'(T_RP - 2);
  localparam logic [WW-1:0] RFC_LOAD = WW'(T_RFC - 2);
  localparam logic [RW-1:0] REF_LAST = RW'(NUM_REFRESH);

  seq_state_e    st;
  logic [WW-1:0] wcnt;
  logic [RW-1:0] refs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= SQ_IDLE;
      wcnt <= '0;
      refs <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: if (start) st <= SQ_PRE;
        SQ_PRE: begin
          wcnt <= RP_LOAD;
          st   <= SQ_WAIT_RP;
        end
        SQ_WAIT_RP:
          if (wcnt == '0) st <= SQ_REF;
          else            wcnt <= wcnt - 1'b1;
        SQ_REF: begin
          wcnt <= RFC_LOAD;
          refs <= refs + 1'b1;
          st   <= SQ_WAIT_RFC;
        end
        SQ_WAIT_RFC:
          if (wcnt == '0) st <= (refs == REF_LAST) ? SQ_DONE : SQ_REF;
          else            wcnt <= wcnt - 1'b1;
        SQ_DONE: begin
          refs <= '0;
          st   <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      SQ_PRE:  cmd = CMD_PRECHARGE;
      SQ_REF:  cmd = CMD_REFRESH;
      default: cmd = CMD_NOP;
    endcase
    a10  = (st == SQ_PRE);
    done = (st == SQ_DONE);
    idle = (st == SQ_IDLE);
  end
endmodule

// File: rtl/sdram_refresh_engine.sv
module sdram_refresh_engine
  import sdram_ref_pkg::*;
#(
  parameter int REFI_CYCLES = 1500,
  parameter int T_RP        = 2,
  parameter int T_RFC       = 7,
  parameter int NUM_REFRESH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_done,
  input  logic ref_grant,
  output logic ref_req,
  output logic ref_done,
  output logic sdram_cs_n,
  output logic sdram_ras_n,
  output logic sdram_cas_n,
  output logic sdram_we_n,
  output logic sdram_a10
);
  logic       seq_idle;
  logic       seq_start;
  sdram_cmd_e seq_cmd;

  assign seq_start = ref_grant & ref_req & seq_idle;

  ref_interval_timer #(.INTERVAL(REFI_CYCLES)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_done (init_done),
    .start     (seq_start),
    .req       (ref_req)
  );

  ref_cmd_sequencer #(
    .T_RP        (T_RP),
    .T_RFC       (T_RFC),
    .NUM_REFRESH (NUM_REFRESH)
  ) seq_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (seq_start),
    .idle  (seq_idle),
    .cmd   (seq_cmd),
    .a10   (sdram_a10),
    .done  (ref_done)
  );

  assign {sdram_cs_n, sdram_ras_n, sdram_cas_n, sdram_we_n} = seq_cmd;
endmodule

// File: rtl/sdram_refresh_engine_chk.sv
module sdram_refresh_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic init_done,
  input logic ref_grant,
  input logic ref_req,
  input logic ref_done,
  input logic sdram_cs_n,
  input logic sdram_ras_n,
  input logic sdram_cas_n,
  input logic sdram_we_n,
  input logic sdram_a10
);
  logic [3:0] pins;
  assign pins = {sdram_cs_n, sdram_ras_n, sdram_cas_n, sdram_we_n};

  // R10: only NOP, PRECHARGE or AUTO REFRESH on the bus
  a_r10_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0111) || (pins == 4'b0010) || (pins == 4'b0001));

  // R10: A10 high only alongside PRECHARGE
  a_r10_a10_only_pre: assert property (@(posedge clk) disable iff (!rst_n)
    sdram_a10 |-> (pins == 4'b0010));

  // R3: request falls only after a grant
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_grant) |=> ref_req);

  // R7: done is a single-cycle pulse carried with NOP
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> !ref_done);
  a_r7_done_nop: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |-> (pins == 4'b0111));

  // R5: every refresh command is preceded by a NOP cycle
  a_r5_ref_after_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0001) |-> ($past(pins) == 4'b0111));
endmodule

bind sdram_refresh_engine sdram_refresh_engine_chk chk_i (.*);

// File: tb/sdram_refresh_engine_tb_top.sv
module sdram_refresh_engine_tb_top;
  localparam int REFI  = 40;
  localparam int TRP   = 3;
  localparam int TRFC  = 5;
  localparam int NREF  = 2;

  typedef struct {
    logic [3:0] cmd;
    logic       a10;
    logic       done;
    int         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_done = 1'b0;
  logic ref_grant = 1'b0;
  logic ref_req, ref_done;
  logic cs_n, ras_n, cas_n, we_n, a10;

  int checks = 0;
  int fails  = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  sdram_refresh_engine #(
    .REFI_CYCLES (REFI),
    .T_RP        (TRP),
    .T_RFC       (TRFC),
    .NUM_REFRESH (NREF)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_done   (init_done),
    .ref_grant   (ref_grant),
    .ref_req     (ref_req),
    .ref_done    (ref_done),
    .sdram_cs_n  (cs_n),
    .sdram_ras_n (ras_n),
    .sdram_cas_n (cas_n),
    .sdram_we_n  (we_n),
    .sdram_a10   (a10)
  );

  wire [3:0] pins = {cs_n, ras_n, cas_n, we_n};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic push(input logic [3:0] c, input logic a, input logic d, input int t);
    exp_t e;
    e.cmd = c; e.a10 = a; e.done = d; e.tag = t;
    exp_q.push_back(e);
  endtask

  // Driver: grant the pending request and script the expected trace
  task automatic do_grant();
    @(negedge clk);
    ref_grant = 1'b1;
    push(4'b0010, 1'b1, 1'b0, 4);                        // R4
    for (int i = 0; i < TRP - 1; i++) push(4'b0111, 1'b0, 1'b0, 5);  // R5
    for (int k = 0; k < NREF; k++) begin
      push(4'b0001, 1'b0, 1'b0, (k == 0) ? 5 : 6);       // R5 / R6
      for (int i = 0; i < TRFC - 1; i++) push(4'b0111, 1'b0, 1'b0, 6);
    end
    push(4'b0111, 1'b0, 1'b1, 7);                        // R7
    @(negedge clk);
    ref_grant = 1'b0;
  endtask

  // Monitor: samples 1 ns after each rising edge
  int  ec = 0;
  int  last_start = 0;
  bit  init_seen = 1'b0;
  bit  req_prev = 1'b0;
  bit  first_round = 1'b1;

  initial begin
    forever begin
      @(posedge clk);
      #1;
      ec++;
      if (rst_n) begin
        if (exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          chk(pins == e.cmd, $sformatf("R%0d", e.tag), "command", pins, e.cmd);
          chk(a10 == e.a10, $sformatf("R%0d", e.tag), "a10", a10, e.a10);
          chk(ref_done == e.done, $sformatf("R%0d", e.tag), "done", ref_done, e.done);
        end else begin
          // R9 / R10: outside a sequence only NOP, no done
          chk(pins == 4'b0111, "R9", "idle command", pins, 4'b0111);
          chk(!ref_done && !a10, "R7", "idle done/a10", {ref_done, a10}, 0);
        end
        if (init_done && !init_seen) begin
          init_seen = 1'b1;
          last_start = ec;
        end
        if (!init_seen) chk(!ref_req, "R2", "request before init", ref_req, 0);
        if (ref_req && !req_prev) begin
          chk(ec - last_start == REFI, first_round ? "R2" : "R8",
              "request spacing", ec - last_start, REFI);
          first_round = 1'b0;
        end
        if (req_prev && !ref_req)
          chk(ref_grant, "R3", "request dropped without grant", ref_grant, 1);
        if (ref_grant && req_prev) last_start = ec;
      end
      req_prev = ref_req;
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL all-requirements watchdog: actual=%0d expected=<%0d cycles", 20000, 20000);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!ref_req, "R1", "req in reset", ref_req, 0);
    chk(!ref_done, "R1", "done in reset", ref_done, 0);
    chk(pins == 4'b0111, "R1", "cmd in reset", pins, 4'b0111);
    chk(!a10, "R1", "a10 in reset", a10, 0);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    // R9: grant before init and without request
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
    @(negedge clk);
    chk(pins == 4'b0111 && !ref_req, "R9", "grant before init", {pins, ref_req}, 4'b1110);
    init_done = 1'b1;
    wait (ref_req);
    // R3: leave the request unserved for a while
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(ref_req, "R3", "request held", ref_req, 1);
    end
    do_grant();
    repeat (4) @(negedge clk);
    // R9: stray grant mid-sequence with request low
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
    chk(!ref_req, "R9", "no request after stray grant", ref_req, 0);
    wait (exp_q.size() == 0);
    // R8: second round, granted at once
    wait (ref_req);
    do_grant();
    wait (exp_q.size() == 0);
    repeat (10) @(negedge clk);
    chk(!ref_req, "R8", "request not yet due", ref_req, 0);
    finish_run();
  end
endmodule